// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

This block sits at the issue stage of a two-wide in-order core. Each cycle it receives two decoded instructions, the older one and the younger one in program order. Each carries a valid bit and a 4-bit class code. The block decides whether both issue together, only the older one issues, or nothing issues. The core has two execution pipes. The M-pipe holds the address/add unit, so it serves loads, stores and simple integer work. The F-pipe holds a set of units of which only one may be claimed per cycle: an integer adder, the branch unit, the integer multiply/divide unit, the FP adder, the FP multiplier and the FP divide/square-root unit.

A pair is legal only in an asymmetric shape. The first slot holds an integer ALU operation, a load or a store, and that instruction always goes down the M-pipe. The second slot holds an ALU operation, an integer multiply/divide, a HI/LO move, a branch or an FP operation, and that instruction goes down the F-pipe. An older instruction that only fits the second slot issues alone on the F-pipe. A branch always ends the bundle. Unknown and multi-operation instructions take both slots. Three busy inputs from the iterative units hold back any instruction that needs an occupied unit, and also every instruction younger than it. Operand dependencies are not checked here. All decisions are registered and appear one cycle after the inputs are sampled.

Top module: `pair_issue_gate`

## Requirements
- R1: While rst_n is low at a rising edge, every output is zero after that edge.
- R2: The younger instruction never issues unless the older one issues in the same cycle, and an invalid older instruction issues nothing.
- R3: An older class 0 (ALU), 1 (load) or 2 (store) instruction paired with a valid, unblocked younger class 0 or 3..9 instruction issues both. The older one goes on the M-pipe (older_fpipe=0) and the younger one on the F-pipe (younger_fpipe=1).
- R4: A younger class 1 (load), 2 (store) or 10..15 (multi/unknown) instruction is never paired.
- R5: An older class 3..9 instruction issues alone on the F-pipe (older_fpipe=1).
- R6: An older class 6 (branch) instruction never has a younger instruction issued beside it.
- R7: An older class 10 (multi) instruction, or one of the unused codes 11..15, issues alone with solo_dispatch=1 and fpipe_claim=0.
- R8: At most one bit of fpipe_claim is set in any cycle.
- R9: iter_busy bit 0 holds classes 3, 4 and 5 (integer multiply, divide, HI/LO move). Bit 1 holds class 8 (FP multiply) and bit 2 holds class 9 (FP divide/sqrt). A held older instruction blocks both slots. A held younger instruction lets the older one issue alone.
- R10: fpipe_claim names the F-pipe unit taken: bit 0 integer add (class 0 in the F-pipe), bit 1 branch (6), bit 2 multiply/divide (3, 4, 5), bit 3 FP add (7), bit 4 FP multiply (8), bit 5 FP divide/sqrt (9).
- R11: Outputs reflect the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| old_vld | input | 1 | Older instruction present |
| old_cls | input | 4 | Older instruction class code |
| yng_vld | input | 1 | Younger instruction present |
| yng_cls | input | 4 | Younger instruction class code |
| iter_busy | input | 3 | Occupied iterative units (muldiv, fmul, fdiv) |
| issue_older | output | 1 | Older instruction issues |
| issue_younger | output | 1 | Younger instruction issues |
| older_fpipe | output | 1 | Older instruction routed to the F-pipe |
| younger_fpipe | output | 1 | Younger instruction routed to the F-pipe |
| solo_dispatch | output | 1 | Older instruction occupies both issue slots |
| fpipe_claim | output | 6 | One-hot F-pipe unit taken this cycle |

## Verification
Some properties are checked on every cycle. These are: the younger never issues without the older, the F-pipe claim is one-hot or empty, a branch or a bad second-slot class never has a partner, solo dispatch stays alone, and a busy unit holds back its older instruction. Other behaviour is only visible in the bench scenarios, which sweep every class pair under every busy pattern. These cover the exact pipe routing, the mapping from each class to its claim bit, the held-younger case in which the older still issues, and the reset values.

// File: rtl/pair_pkg.sv
// Shared widths, class codes and decoded-slot type for the pairing checker.
// Assumes class codes 11..15 are unused and are treated like multi.
package pair_pkg;
    localparam int CLS_W  = 4;
    localparam int FU_N   = 6;
    localparam int ITER_N = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU    = 4'd0,
        CLS_LOAD   = 4'd1,
        CLS_STORE  = 4'd2,
        CLS_IMUL   = 4'd3,
        CLS_IDIV   = 4'd4,
        CLS_HILO   = 4'd5,
        CLS_BRANCH = 4'd6,
        CLS_FADD   = 4'd7,
        CLS_FMUL   = 4'd8,
        CLS_FDIV   = 4'd9,
        CLS_MULTI  = 4'd10
    } icls_e;

    // F-pipe unit bit positions
    localparam int FU_IADD = 0;
    localparam int FU_BR   = 1;
    localparam int FU_MD   = 2;
    localparam int FU_FADD = 3;
    localparam int FU_FMUL = 4;
    localparam int FU_FDIV = 5;

    // Iterative unit busy bit positions
    localparam int IT_MD   = 0;
    localparam int IT_FMUL = 1;
    localparam int IT_FDIV = 2;

    typedef struct packed {
        logic              s0_ok;  // may sit in the first slot (M-pipe)
        logic              s1_ok;  // may sit in the second slot (F-pipe)
        logic              multi;  // needs both slots
        logic [FU_N-1:0]   fu;     // F-pipe unit when placed on the F-pipe
        logic [ITER_N-1:0] iter;   // iterative units it must find idle
    } dec_t;

    typedef struct packed {
        logic            iss_o;
        logic            iss_y;
        logic            o_f;
        logic            y_f;
        logic            solo;
        logic [FU_N-1:0] claim;
    } issue_t;
endpackage

// File: rtl/pair_slot_decode.sv
// Maps one class code to slot eligibility, F-pipe unit and iterative needs.
// Purely combinational; assumes codes above CLS_MULTI mean unknown.
module pair_slot_decode
    import pair_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output dec_t             dec
);
    // Class table lookup
    always_comb begin
        dec = '0;
        case (cls)
            CLS_ALU: begin
                dec.s0_ok = 1'b1;
                dec.s1_ok = 1'b1;
                dec.fu[FU_IADD] = 1'b1;
            end
            CLS_LOAD, CLS_STORE: dec.s0_ok = 1'b1;
            CLS_IMUL, CLS_IDIV, CLS_HILO: begin
                dec.s1_ok = 1'b1;
                dec.fu[FU_MD] = 1'b1;
                dec.iter[IT_MD] = 1'b1;
            end
            CLS_BRANCH: begin
                dec.s1_ok = 1'b1;
                dec.fu[FU_BR] = 1'b1;
            end
            CLS_FADD: begin
                dec.s1_ok = 1'b1;
                dec.fu[FU_FADD] = 1'b1;
            end
            CLS_FMUL: begin
                dec.s1_ok = 1'b1;
                dec.fu[FU_FMUL] = 1'b1;
                dec.iter[IT_FMUL] = 1'b1;
            end
            CLS_FDIV: begin
                dec.s1_ok = 1'b1;
                dec.fu[FU_FDIV] = 1'b1;
                dec.iter[IT_FDIV] = 1'b1;
            end
            default: dec.multi = 1'b1;
        endcase
    end
endmodule

// File: rtl/pair_arbiter.sv
// Combines two decoded slots and the busy flags into one issue decision.
// Assumes the first-slot class set is entirely M-pipe, so a pair can take at
// most one F-pipe unit (the younger's); a lone older may take one itself.
module pair_arbiter
    import pair_pkg::*;
(
    input  logic              o_vld,
    input  logic              y_vld,
    input  dec_t              dec_o,
    input  dec_t              dec_y,
    input  logic [ITER_N-1:0] busy,
    output issue_t            nxt
);
    logic o_blk;
    logic y_blk;

    // Busy gating for each slot
    always_comb begin
        o_blk = |(dec_o.iter & busy);
        y_blk = |(dec_y.iter & busy);
    end

    // Issue, routing and F-pipe claim
    always_comb begin
        nxt       = '0;
        nxt.iss_o = o_vld & ~o_blk;
        nxt.solo  = nxt.iss_o & dec_o.multi;
        nxt.o_f   = nxt.iss_o & ~dec_o.s0_ok & ~dec_o.multi;
        nxt.iss_y = nxt.iss_o & dec_o.s0_ok & y_vld & dec_y.s1_ok
                    & ~dec_y.multi & ~y_blk;
        nxt.y_f   = nxt.iss_y;
        nxt.claim = (nxt.o_f ? dec_o.fu : '0) | (nxt.iss_y ? dec_y.fu : '0);
    end
endmodule

// File: rtl/pair_issue_gate.sv
// Top of the dual-issue pairing checker: decodes both slots, arbitrates and
// registers the decision. Assumes operands are already known to be ready.
module pair_issue_gate
    import pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              old_vld,
    input  logic [CLS_W-1:0]  old_cls,
    input  logic              yng_vld,
    input  logic [CLS_W-1:0]  yng_cls,
    input  logic [ITER_N-1:0] iter_busy,
    output logic              issue_older,
    output logic              issue_younger,
    output logic              older_fpipe,
    output logic              younger_fpipe,
    output logic              solo_dispatch,
    output logic [FU_N-1:0]   fpipe_claim
);
    localparam int SLOTS = 2;

    logic [SLOTS-1:0][CLS_W-1:0] cls_vec;
    dec_t                        dec_vec [SLOTS];
    issue_t                      nxt;
    issue_t                      cur;

    assign cls_vec[0] = old_cls;
    assign cls_vec[1] = yng_cls;

    // One decoder per issue slot
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        pair_slot_decode u_dec (
            .cls (cls_vec[g]),
            .dec (dec_vec[g])
        );
    end

    pair_arbiter u_arb (
        .o_vld (old_vld),
        .y_vld (yng_vld),
        .dec_o (dec_vec[0]),
        .dec_y (dec_vec[1]),
        .busy  (iter_busy),
        .nxt   (nxt)
    );

    // Decision register
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
    end

    assign issue_older   = cur.iss_o;
    assign issue_younger = cur.iss_y;
    assign older_fpipe   = cur.o_f;
    assign younger_fpipe = cur.y_f;
    assign solo_dispatch = cur.solo;
    assign fpipe_claim   = cur.claim;
endmodule

// File: rtl/pair_checker.sv
// Cycle-by-cycle properties of pair_issue_gate, attached by bind below.
module pair_checker
    import pair_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              old_vld,
    input logic [CLS_W-1:0]  old_cls,
    input logic [CLS_W-1:0]  yng_cls,
    input logic [ITER_N-1:0] iter_busy,
    input logic              issue_older,
    input logic              issue_younger,
    input logic              solo_dispatch,
    input logic [FU_N-1:0]   fpipe_claim
);
    assert_young_needs_old_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_younger |-> issue_older);

    assert_old_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_older |-> $past(old_vld));

    assert_one_funit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fpipe_claim));

    assert_branch_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (old_cls == CLS_BRANCH) |=> !issue_younger);

    assert_bad_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (yng_cls == CLS_LOAD || yng_cls == CLS_STORE || yng_cls >= CLS_MULTI)
        |=> !issue_younger);

    assert_solo_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        solo_dispatch |-> (!issue_younger && fpipe_claim == '0));

    assert_md_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_busy[IT_MD] && (old_cls == CLS_IMUL || old_cls == CLS_IDIV ||
                              old_cls == CLS_HILO)) |=> !issue_older);

    assert_fdiv_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_busy[IT_FDIV] && old_cls == CLS_FDIV) |=> !issue_older);
endmodule

bind pair_issue_gate pair_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .old_vld       (old_vld),
    .old_cls       (old_cls),
    .yng_cls       (yng_cls),
    .iter_busy     (iter_busy),
    .issue_older   (issue_older),
    .issue_younger (issue_younger),
    .solo_dispatch (solo_dispatch),
    .fpipe_claim   (fpipe_claim)
);

// File: tb/pair_issue_gate_tb.sv
module pair_issue_gate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       old_vld = 1'b0;
    logic [3:0] old_cls = '0;
    logic       yng_vld = 1'b0;
    logic [3:0] yng_cls = '0;
    logic [2:0] iter_busy = '0;
    logic       issue_older, issue_younger, older_fpipe, younger_fpipe, solo_dispatch;
    logic [5:0] fpipe_claim;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    pair_issue_gate u_dut (
        .clk(clk), .rst_n(rst_n),
        .old_vld(old_vld), .old_cls(old_cls),
        .yng_vld(yng_vld), .yng_cls(yng_cls),
        .iter_busy(iter_busy),
        .issue_older(issue_older), .issue_younger(issue_younger),
        .older_fpipe(older_fpipe), .younger_fpipe(younger_fpipe),
        .solo_dispatch(solo_dispatch), .fpipe_claim(fpipe_claim)
    );

    // Reference behaviour from the requirements
    function automatic bit first_ok(int c);   return c <= 2; endfunction
    function automatic bit second_ok(int c);  return c == 0 || (c >= 3 && c <= 9); endfunction
    function automatic bit is_multi(int c);   return c >= 10; endfunction
    function automatic bit held(int c, int b);
        if (c >= 3 && c <= 5) return b[0];
        if (c == 8) return b[1];
        if (c == 9) return b[2];
        return 1'b0;
    endfunction
    function automatic int unit_bit(int c);   // R10 mapping, -1 for none
        case (c)
            0: return 0;
            6: return 1;
            3, 4, 5: return 2;
            7: return 3;
            8: return 4;
            9: return 5;
            default: return -1;
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (ov=%0d oc=%0d yv=%0d yc=%0d busy=%0d)",
                     req, what, act, exp, old_vld, old_cls, yng_vld, yng_cls, iter_busy);
        end
    endtask

    // Drive one input set, then compare one cycle later (R11: registered)
    task automatic apply(bit ov, int oc, bit yv, int yc, int b);
        bit e_o, e_y, e_of, e_yf, e_solo;
        int e_claim;
        string tag;
        old_vld = ov; old_cls = oc[3:0]; yng_vld = yv; yng_cls = yc[3:0]; iter_busy = b[2:0];
        e_o  = ov && !held(oc, b);
        e_solo = e_o && is_multi(oc);
        e_of = e_o && !first_ok(oc) && !is_multi(oc);
        e_y  = e_o && first_ok(oc) && yv && second_ok(yc) && !held(yc, b);
        e_yf = e_y;
        e_claim = 0;
        if (e_of && unit_bit(oc) >= 0) e_claim |= (1 << unit_bit(oc));
        if (e_y && unit_bit(yc) >= 0)  e_claim |= (1 << unit_bit(yc));
        if (!ov) tag = "R2";
        else if (held(oc, b)) tag = "R9";
        else if (is_multi(oc)) tag = "R7";
        else if (oc == 6) tag = "R6";
        else if (!first_ok(oc)) tag = "R5";
        else if (yv && held(yc, b)) tag = "R9";
        else if (!second_ok(yc)) tag = "R4";
        else tag = "R3";
        @(negedge clk);
        check(tag, "issue_older", int'(issue_older), int'(e_o));
        check(tag, "issue_younger", int'(issue_younger), int'(e_y));
        check(tag, "older_fpipe", int'(older_fpipe), int'(e_of));
        check(tag, "younger_fpipe", int'(younger_fpipe), int'(e_yf));
        check(tag, "solo_dispatch", int'(solo_dispatch), int'(e_solo));
        check("R10", "fpipe_claim", int'(fpipe_claim), e_claim);
        check("R8", "claim_onehot0", int'($countones(fpipe_claim) <= 1), 1);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, with busy-free legal inputs present
        old_vld = 1'b1; yng_vld = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "issue_older", int'(issue_older), 0);
        check("R1", "issue_younger", int'(issue_younger), 0);
        check("R1", "fpipe_claim", int'(fpipe_claim), 0);
        check("R1", "solo_dispatch", int'(solo_dispatch), 0);
        old_vld = 1'b0; yng_vld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // Directed cases
        apply(1, 1, 1, 7, 0);   // R3 load + FP add
        apply(1, 0, 1, 0, 0);   // R3 ALU + ALU: F-pipe integer add
        apply(1, 2, 1, 1, 0);   // R4 store + load
        apply(1, 6, 1, 0, 0);   // R6 branch first
        apply(1, 8, 1, 0, 0);   // R5 FP multiply first
        apply(1, 10, 1, 0, 0);  // R7 multi
        apply(1, 13, 1, 0, 0);  // R7 unknown code
        apply(1, 3, 1, 0, 1);   // R9 older held
        apply(1, 0, 1, 9, 4);   // R9 younger held, older alone
        apply(0, 0, 1, 0, 0);   // R2 no older
        // Full sweep
        for (int b = 0; b < 8; b++)
            for (int oc = 0; oc < 16; oc++)
                for (int yc = 0; yc < 16; yc++)
                    for (int v = 0; v < 4; v++)
                        apply(v[0], oc, v[1], yc, b);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule